// File: doc/BRIEF.md
# Reorder Buffer with Operand Lookup

This block is the in-order retirement buffer of an out-of-order RISC-V core. The issue stage hands it one instruction at a time. The instruction is written into the slot at the tail pointer together with its instruction word, the next PC the front end assumed, and its destination register if it has one. Two completion buses, one from the ALU and one from the memory unit, deliver results tagged with a slot index. The buffer retires instructions from the head, one per cycle, and only when the head slot holds its result. Retirement therefore follows program order no matter in which order the results arrive.

In the cycle after an instruction issues, the buffer searches its occupied slots for the values of that instruction's two source registers. The search runs from the oldest slot toward the newest. The slot just written, which belongs to the issuing instruction itself, is left out. The youngest slot that writes a register decides the result: if that slot holds a value, the value is forwarded, and if it is still waiting, nothing is forwarded. The buffer also checks each resolved PC against the assumed one and keeps the target of the most recent indirect jump (jalr). When a designated terminating instruction retires, it raises a halt word that carries an exit code taken from register a0.

Top module: `rob_core`

## Requirements
- R1: A synchronous reset leaves the buffer empty: free_count equals the depth (32), issue_ready is 1, and commit_valid, pred_valid, op1_found, op2_found and halt_word are all 0.
- R2: An accepted issue writes the slot named by issue_idx, advances the tail by one modulo the depth and lowers free_count by one. After the depth's worth of slots has been used, issue_idx wraps back to 0.
- R3: When free_count is 0, issue_ready is 0 and an asserted issue_valid allocates nothing, so free_count stays 0.
- R4: A completion bus is valid only when its 2-bit status is 2'b10. The waiting slot it names then stores the value and becomes ready. Any other status code leaves the slot waiting.
- R5: commit_valid is 1 exactly when the head slot is ready. Slots retire one per cycle in allocation order, and a ready younger slot does not retire while the head is still waiting.
- R6: The lookup for a source register returns found=1 and the value of the youngest matching slot when that slot is ready. Slots without a destination register are never matched.
- R7: A matching slot that is still waiting and is younger than a ready match clears found to 0.
- R8: The lookup runs only in the cycle after an accepted issue. It covers the occupied slots except the newest one (the issuing instruction's own slot), and its result appears at the clock edge that ends that cycle and holds until the next lookup.
- R9: An ALU completion for a jalr slot (opcode bits [6:0] = 7'b1100111) sets pred_valid and loads pred_pc with the resolved target, and never marks that slot as mispredicted. Issuing a jalr clears pred_valid.
- R10: An ALU completion for any other slot marks it mispredicted when the resolved PC differs from the recorded next PC. commit_mispredict shows this mark when the slot retires.
- R11: When a slot holding the word 32'h0FF00513 retires, halt_word becomes {1'b1, a0_low} one edge later and then holds that value until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_valid | input | 1 | Issue request |
| issue_insn | input | 32 | Instruction word being issued |
| issue_next_pc | input | 32 | Next PC assumed by the front end |
| issue_has_rd | input | 1 | Instruction writes a register |
| issue_rd | input | 5 | Destination register |
| issue_ready | output | 1 | A free slot exists |
| issue_idx | output | 5 | Slot an issue this cycle would take |
| free_count | output | 6 | Number of free slots |
| src1 | input | 5 | First source register of the instruction issued last cycle |
| src2 | input | 5 | Second source register of the instruction issued last cycle |
| op1_found | output | 1 | Value for src1 forwarded from the buffer |
| op1_value | output | 32 | Forwarded src1 value |
| op2_found | output | 1 | Value for src2 forwarded from the buffer |
| op2_value | output | 32 | Forwarded src2 value |
| alu_status | input | 2 | ALU bus status, 2'b10 = result present |
| alu_idx | input | 5 | Slot the ALU result belongs to |
| alu_value | input | 32 | ALU result |
| alu_pc | input | 32 | Resolved next PC |
| mem_status | input | 2 | Memory bus status, 2'b10 = result present |
| mem_idx | input | 5 | Slot the memory result belongs to |
| mem_value | input | 32 | Memory result |
| a0_low | input | 8 | Low byte of register a0 |
| commit_valid | output | 1 | Head slot retires this cycle |
| commit_idx | output | 5 | Retiring slot |
| commit_has_rd | output | 1 | Retiring slot writes a register |
| commit_rd | output | 5 | Retiring destination register |
| commit_value | output | 32 | Retiring result |
| commit_mispredict | output | 1 | Retiring slot resolved to a different PC |
| pred_valid | output | 1 | pred_pc holds a resolved jalr target |
| pred_pc | output | 32 | Latest resolved jalr target |
| halt_word | output | 9 | Halt flag in bit 8, exit code in bits 7:0 |

## Verification
The lookup corner cases are the core of the bench. In one scenario a register has two ready writers, and the search must forward the younger one. A slot with no destination but a matching register field must not be matched; a design that skipped this check would forward 0xBAD. A ready writer followed by a pending writer must give no match; a design that took the oldest or the first writer would forward stale data. The issuing instruction writes the searched register itself, so a design that searched one slot too far would drop a valid match. The bench also fills all 32 slots and retires them while completions arrive one per cycle, which exposes tail wrap errors, acceptance when full and out-of-order retirement. The jalr, mispredict and halt checks catch a design that flags jalr targets as mispredicts, loses the exit code or lets the halt word change after it is set.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int XLEN = 32;
    localparam int REGW = 5;
    localparam logic [6:0] OPC_JALR = 7'b1100111;
    localparam logic [1:0] BUS_DONE = 2'b10;

    typedef enum logic [1:0] {
        ST_FREE  = 2'b00,
        ST_WAIT  = 2'b01,
        ST_READY = 2'b11
    } slot_state_e;

    typedef struct packed {
        slot_state_e       st;
        logic [XLEN-1:0]   insn;
        logic [XLEN-1:0]   pc;
        logic              has_rd;
        logic [REGW-1:0]   rd;
        logic [XLEN-1:0]   value;
        logic              pc_ready;
        logic              mismatch;
    } slot_t;

    typedef struct packed {
        logic              ready;
        logic              has_rd;
        logic [REGW-1:0]   rd;
        logic [XLEN-1:0]   value;
    } probe_t;
endpackage

// File: rtl/rob_lookup.sv
module rob_lookup
    import rob_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  probe_t                     slots [DEPTH],
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH):0]     count,
    input  logic [REGW-1:0]            src,
    output logic                       found,
    output logic [XLEN-1:0]            value
);
    localparam int IDXW = $clog2(DEPTH);
    localparam int CW   = IDXW + 1;

    logic [IDXW-1:0] idx;

    // Oldest to newest; the newest occupied slot is skipped, later matches override earlier ones.
    always_comb begin
        found = 1'b0;
        value = '0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + IDXW'(k);
            if ((CW'(k + 1) < count) && slots[idx].has_rd && (slots[idx].rd == src)) begin
                if (slots[idx].ready) begin
                    found = 1'b1;
                    value = slots[idx].value;
                end else begin
                    found = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/rob_halt.sv
module rob_halt
    import rob_pkg::*;
#(
    parameter logic [XLEN-1:0] STOP_WORD = 32'h0FF00513
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [XLEN-1:0]  insn,
    input  logic [7:0]       a0_low,
    output logic [8:0]       halt_word
);
    typedef struct packed {
        logic [8:0] word;
    } halt_state_t;

    halt_state_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (fire && (insn == STOP_WORD) && !h_q.word[8]) begin
            h_d.word = {1'b1, a0_low};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    assign halt_word = h_q.word;

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        h_q.word[8] |=> $stable(h_q.word)); // R11
    AST_HALT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (h_q.word != 9'd0) |-> h_q.word[8]); // R11
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int               DEPTH     = 32,
    parameter logic [XLEN-1:0]  STOP_WORD = 32'h0FF00513
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_valid,
    input  logic [XLEN-1:0]           issue_insn,
    input  logic [XLEN-1:0]           issue_next_pc,
    input  logic                      issue_has_rd,
    input  logic [REGW-1:0]           issue_rd,
    output logic                      issue_ready,
    output logic [$clog2(DEPTH)-1:0]  issue_idx,
    output logic [$clog2(DEPTH):0]    free_count,
    input  logic [REGW-1:0]           src1,
    input  logic [REGW-1:0]           src2,
    output logic                      op1_found,
    output logic [XLEN-1:0]           op1_value,
    output logic                      op2_found,
    output logic [XLEN-1:0]           op2_value,
    input  logic [1:0]                alu_status,
    input  logic [$clog2(DEPTH)-1:0]  alu_idx,
    input  logic [XLEN-1:0]           alu_value,
    input  logic [XLEN-1:0]           alu_pc,
    input  logic [1:0]                mem_status,
    input  logic [$clog2(DEPTH)-1:0]  mem_idx,
    input  logic [XLEN-1:0]           mem_value,
    input  logic [7:0]                a0_low,
    output logic                      commit_valid,
    output logic [$clog2(DEPTH)-1:0]  commit_idx,
    output logic                      commit_has_rd,
    output logic [REGW-1:0]           commit_rd,
    output logic [XLEN-1:0]           commit_value,
    output logic                      commit_mispredict,
    output logic                      pred_valid,
    output logic [XLEN-1:0]           pred_pc,
    output logic [8:0]                halt_word
);
    localparam int IDXW = $clog2(DEPTH);
    localparam int CW   = IDXW + 1;
    localparam int NSRC = 2;

    typedef struct packed {
        logic [IDXW-1:0] head;
        logic [IDXW-1:0] tail;
        logic [CW-1:0]   count;
        logic            issued_last;
        logic            pred_valid;
        logic [XLEN-1:0] pred_pc;
        logic [NSRC-1:0] op_found;
        logic [XLEN-1:0] op1_value;
        logic [XLEN-1:0] op2_value;
    } ctl_t;

    ctl_t   c_d, c_q;
    slot_t  slot_d [DEPTH];
    slot_t  slot_q [DEPTH];
    probe_t probe  [DEPTH];

    logic            accept;
    logic            retire;
    logic [REGW-1:0] src_sel [NSRC];
    logic            hit     [NSRC];
    logic [XLEN-1:0] hit_val [NSRC];

    assign src_sel[0] = src1;
    assign src_sel[1] = src2;

    for (genvar i = 0; i < DEPTH; i++) begin : g_probe
        assign probe[i] = '{ready:  (slot_q[i].st == ST_READY),
                            has_rd: slot_q[i].has_rd,
                            rd:     slot_q[i].rd,
                            value:  slot_q[i].value};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        rob_lookup #(.DEPTH(DEPTH)) u_lookup (
            .slots (probe),
            .head  (c_q.head),
            .count (c_q.count),
            .src   (src_sel[g]),
            .found (hit[g]),
            .value (hit_val[g])
        );
    end

    always_comb begin
        c_d = c_q;
        for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];

        accept = issue_valid && (c_q.count != CW'(DEPTH));
        retire = (c_q.count != '0) && (slot_q[c_q.head].st == ST_READY);

        if (retire) begin
            slot_d[c_q.head].st = ST_FREE;
            c_d.head = c_q.head + 1'b1;
        end

        if (accept) begin
            slot_d[c_q.tail] = '{st: ST_WAIT, insn: issue_insn, pc: issue_next_pc,
                                 has_rd: issue_has_rd, rd: issue_rd, value: '0,
                                 pc_ready: 1'b0, mismatch: 1'b0};
            c_d.tail = c_q.tail + 1'b1;
            if (issue_insn[6:0] == OPC_JALR) c_d.pred_valid = 1'b0;
        end

        if ((mem_status == BUS_DONE) && (slot_q[mem_idx].st == ST_WAIT)) begin
            slot_d[mem_idx].value = mem_value;
            slot_d[mem_idx].st    = ST_READY;
        end

        if ((alu_status == BUS_DONE) && (slot_q[alu_idx].st == ST_WAIT)) begin
            slot_d[alu_idx].value = alu_value;
            slot_d[alu_idx].st    = ST_READY;
            if (!slot_q[alu_idx].pc_ready) begin
                slot_d[alu_idx].pc_ready = 1'b1;
                if (slot_q[alu_idx].insn[6:0] == OPC_JALR) begin
                    c_d.pred_valid = 1'b1;
                    c_d.pred_pc    = alu_pc;
                end else if (alu_pc != slot_q[alu_idx].pc) begin
                    slot_d[alu_idx].mismatch = 1'b1;
                end
            end
        end

        c_d.count       = c_q.count + CW'(accept) - CW'(retire);
        c_d.issued_last = accept;

        if (c_q.issued_last) begin
            c_d.op_found  = {hit[1], hit[0]};
            c_d.op1_value = hit_val[0];
            c_d.op2_value = hit_val[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            c_q <= c_d;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    rob_halt #(.STOP_WORD(STOP_WORD)) u_halt (
        .clk       (clk),
        .rst       (rst),
        .fire      (retire),
        .insn      (slot_q[c_q.head].insn),
        .a0_low    (a0_low),
        .halt_word (halt_word)
    );

    assign issue_ready       = (c_q.count != CW'(DEPTH));
    assign issue_idx         = c_q.tail;
    assign free_count        = CW'(DEPTH) - c_q.count;
    assign op1_found         = c_q.op_found[0];
    assign op2_found         = c_q.op_found[1];
    assign op1_value         = c_q.op1_value;
    assign op2_value         = c_q.op2_value;
    assign commit_valid      = retire;
    assign commit_idx        = c_q.head;
    assign commit_has_rd     = slot_q[c_q.head].has_rd;
    assign commit_rd         = slot_q[c_q.head].rd;
    assign commit_value      = slot_q[c_q.head].value;
    assign commit_mispredict = slot_q[c_q.head].mismatch;
    assign pred_valid        = c_q.pred_valid;
    assign pred_pc           = c_q.pred_pc;

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((free_count == CW'(DEPTH)) && (halt_word == 9'd0))); // R1
    AST_PTR_COUNT: assert property (@(posedge clk) disable iff (rst)
        (c_q.count == CW'(DEPTH)) || (c_q.count[IDXW-1:0] == IDXW'(c_q.tail - c_q.head))); // R2
    AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
        ((free_count == '0) && !commit_valid) |=> (free_count == '0)); // R3
    AST_COMMIT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (free_count != CW'(DEPTH))); // R5
    AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !c_q.issued_last |=> $stable(c_q.op_found)); // R8
endmodule

// File: tb/rob_core_test.sv
module rob_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [31:0] issue_insn = '0;
    logic [31:0] issue_next_pc = '0;
    logic        issue_has_rd = 1'b0;
    logic [4:0]  issue_rd = '0;
    logic        issue_ready;
    logic [4:0]  issue_idx;
    logic [5:0]  free_count;
    logic [4:0]  src1 = '0;
    logic [4:0]  src2 = '0;
    logic        op1_found, op2_found;
    logic [31:0] op1_value, op2_value;
    logic [1:0]  alu_status = '0;
    logic [4:0]  alu_idx = '0;
    logic [31:0] alu_value = '0;
    logic [31:0] alu_pc = '0;
    logic [1:0]  mem_status = '0;
    logic [4:0]  mem_idx = '0;
    logic [31:0] mem_value = '0;
    logic [7:0]  a0_low = '0;
    logic        commit_valid;
    logic [4:0]  commit_idx;
    logic        commit_has_rd;
    logic [4:0]  commit_rd;
    logic [31:0] commit_value;
    logic        commit_mispredict;
    logic        pred_valid;
    logic [31:0] pred_pc;
    logic [8:0]  halt_word;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rob_core uut (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_insn(issue_insn), .issue_next_pc(issue_next_pc),
        .issue_has_rd(issue_has_rd), .issue_rd(issue_rd), .issue_ready(issue_ready),
        .issue_idx(issue_idx), .free_count(free_count),
        .src1(src1), .src2(src2), .op1_found(op1_found), .op1_value(op1_value),
        .op2_found(op2_found), .op2_value(op2_value),
        .alu_status(alu_status), .alu_idx(alu_idx), .alu_value(alu_value), .alu_pc(alu_pc),
        .mem_status(mem_status), .mem_idx(mem_idx), .mem_value(mem_value),
        .a0_low(a0_low),
        .commit_valid(commit_valid), .commit_idx(commit_idx), .commit_has_rd(commit_has_rd),
        .commit_rd(commit_rd), .commit_value(commit_value), .commit_mispredict(commit_mispredict),
        .pred_valid(pred_valid), .pred_pc(pred_pc), .halt_word(halt_word)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        issue_valid = 1'b0; alu_status = 2'b00; mem_status = 2'b00;
        src1 = '0; src2 = '0; a0_low = '0;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic do_issue(input logic [31:0] insn, input logic [31:0] npc, input logic hrd, input logic [4:0] rd);
        issue_valid = 1'b1; issue_insn = insn; issue_next_pc = npc; issue_has_rd = hrd; issue_rd = rd;
        cyc();
        issue_valid = 1'b0;
    endtask

    task automatic alu_done(input logic [4:0] idx, input logic [31:0] val, input logic [31:0] pc);
        alu_status = 2'b10; alu_idx = idx; alu_value = val; alu_pc = pc;
        cyc();
        alu_status = 2'b00;
    endtask

    task automatic mem_done(input logic [4:0] idx, input logic [31:0] val);
        mem_status = 2'b10; mem_idx = idx; mem_value = val;
        cyc();
        mem_status = 2'b00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        cyc();
        do_reset();
        // R1 reset state
        chk("R1", "free_count", 32'(free_count), 32);
        chk("R1", "issue_ready", 32'(issue_ready), 1);
        chk("R1", "commit_valid", 32'(commit_valid), 0);
        chk("R1", "halt_word", 32'(halt_word), 0);
        chk("R1", "pred_valid", 32'(pred_valid), 0);
        chk("R1", "op1_found", 32'(op1_found), 0);

        // R4 / R5: completion status and in-order retirement
        chk("R2", "first issue_idx", 32'(issue_idx), 0);
        do_issue(32'h00000013, 32'h14, 1'b1, 5'd5);
        do_issue(32'h00000013, 32'h18, 1'b1, 5'd6);
        do_issue(32'h00000013, 32'h1C, 1'b0, 5'd0);
        chk("R2", "free after 3 issues", 32'(free_count), 29);
        mem_done(5'd1, 32'h66);
        chk("R5", "younger ready waits", 32'(commit_valid), 0);
        alu_status = 2'b01; alu_idx = 5'd0; alu_value = 32'h99; cyc();
        chk("R4", "status 01 ignored", 32'(commit_valid), 0);
        alu_status = 2'b11; cyc();
        chk("R4", "status 11 ignored", 32'(commit_valid), 0);
        alu_status = 2'b00;
        alu_done(5'd0, 32'h55, 32'h14);
        chk("R5", "head commit valid", 32'(commit_valid), 1);
        chk("R5", "head commit idx", 32'(commit_idx), 0);
        chk("R4", "head value", commit_value, 32'h55);
        chk("R5", "head rd", 32'(commit_rd), 5);
        chk("R10", "equal pc no mispredict", 32'(commit_mispredict), 0);
        cyc();
        chk("R5", "second commit idx", 32'(commit_idx), 1);
        chk("R4", "mem value", commit_value, 32'h66);
        cyc();
        chk("R5", "waiting head stops", 32'(commit_valid), 0);
        chk("R5", "free after 2 commits", 32'(free_count), 31);

        // R6 / R7 / R8: operand lookup
        do_reset();
        do_issue(32'h00000013, 32'h4, 1'b1, 5'd9);
        do_issue(32'h00000013, 32'h8, 1'b1, 5'd3);
        do_issue(32'h00000013, 32'hC, 1'b1, 5'd3);
        do_issue(32'h00000013, 32'h10, 1'b1, 5'd4);
        do_issue(32'h00000013, 32'h14, 1'b1, 5'd4);
        do_issue(32'h00000013, 32'h18, 1'b0, 5'd3);
        mem_done(5'd1, 32'h111);
        alu_done(5'd2, 32'h222, 32'hC);
        mem_done(5'd3, 32'h444);
        mem_done(5'd5, 32'hBAD);
        src1 = 5'd3; src2 = 5'd4;
        do_issue(32'h00000013, 32'h1C, 1'b1, 5'd3);
        chk("R8", "result not before search", 32'(op1_found), 0);
        cyc();
        chk("R8", "own slot excluded, op1 found", 32'(op1_found), 1);
        chk("R6", "youngest ready writer value", op1_value, 32'h222);
        chk("R7", "pending younger cancels op2", 32'(op2_found), 0);
        mem_done(5'd4, 32'h555);
        do_issue(32'h00000013, 32'h20, 1'b0, 5'd0);
        cyc();
        chk("R6", "op2 found after completion", 32'(op2_found), 1);
        chk("R6", "op2 value", op2_value, 32'h555);
        chk("R7", "older consumer now pending writer", 32'(op1_found), 0);
        cyc();
        chk("R8", "result held without issue", 32'(op2_found), 1);

        // R2 / R3: fill, refuse, drain, wrap
        do_reset();
        for (int k = 0; k < 32; k++) begin
            chk("R2", "issue_idx in fill", 32'(issue_idx), 32'(k));
            do_issue(32'h00000013, 32'(k * 4), 1'b0, 5'd0);
            chk("R2", "free_count in fill", 32'(free_count), 32'(31 - k));
        end
        chk("R3", "issue_ready when full", 32'(issue_ready), 0);
        do_issue(32'h00000013, 32'h0, 1'b1, 5'd1);
        chk("R3", "full refuses issue", 32'(free_count), 0);
        for (int k = 0; k < 32; k++) begin
            alu_done(5'(k), 32'(k * 3), 32'(k * 4));
            chk("R5", "drain commit idx", {31'd0, commit_valid} | (32'(commit_idx) << 1), 32'((k << 1) | 1));
            chk("R5", "drain commit value", commit_value, 32'(k * 3));
        end
        cyc();
        chk("R2", "empty after drain", 32'(free_count), 32);
        chk("R2", "tail wrapped", 32'(issue_idx), 0);

        // R9 / R10: jalr target and mispredict flag
        do_reset();
        do_issue(32'h000080E7, 32'h104, 1'b1, 5'd1);
        alu_done(5'd0, 32'h108, 32'h2000);
        chk("R9", "pred_valid set", 32'(pred_valid), 1);
        chk("R9", "pred_pc", pred_pc, 32'h2000);
        chk("R9", "jalr not mispredicted", 32'(commit_mispredict), 0);
        cyc();
        do_issue(32'h00000013, 32'h44, 1'b1, 5'd2);
        alu_done(5'd1, 32'h7, 32'h80);
        chk("R10", "mispredict flagged", 32'(commit_mispredict), 1);
        chk("R10", "mispredict on commit", 32'(commit_valid), 1);
        cyc();
        do_issue(32'h000080E7, 32'h50, 1'b1, 5'd1);
        chk("R9", "jalr issue clears pred_valid", 32'(pred_valid), 0);

        // R11: halt word
        do_reset();
        a0_low = 8'h2A;
        do_issue(32'h0FF00513, 32'h200, 1'b1, 5'd10);
        alu_done(5'd0, 32'hFF, 32'h200);
        chk("R11", "halt not before commit edge", 32'(halt_word), 0);
        cyc();
        chk("R11", "halt word with exit code", 32'(halt_word), 32'h12A);
        a0_low = 8'h11;
        cyc();
        chk("R11", "halt word holds", 32'(halt_word), 32'h12A);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule